// File: doc/BRIEF.md
# Write-Once System Configuration Register

This block holds a small set of system configuration bits for a chip's integration module. While reset is asserted it samples two strap inputs (a data strap and a bus-error strap) on every clock and keeps the pair seen on the last reset cycle. From that pair it decodes one of three operating modes: single chip, 8-bit expanded or 16-bit expanded. The reset value of the read/write disable bit depends on this mode.

Software reaches the block over a plain register bus with an address, a write strobe, write data, a read strobe and read data. The read/write disable bit takes only the first write to the configuration register after reset; later writes leave it unchanged. The 4-bit interrupt arbitration priority stays writable at all times. A sticky flag records that the first write has happened, and only reset clears it.

Top module: `sys_cfg_once`

## Requirements
- R1: The mode is encoded on `mode_o` as 2'b00 single chip (bus-error strap low), 2'b01 8-bit expanded (bus-error strap high, data strap low) and 2'b10 16-bit expanded (both straps high).
- R2: The straps are sampled on each clock edge while `rst_n` is low. The value taken on the last reset edge is held after release, and later strap changes do not affect `mode_o`.
- R3: After reset, the arbitration priority is 4'hF, the written flag is 0, and the read/write disable bit is 1 in single-chip mode and 0 in either expanded mode.
- R4: `rw_oe` is the inverse of the read/write disable bit. A read of address 0 returns the disable bit in bit 7 and the arbitration priority in bits 3:0, with bits 6:4 zero.
- R5: The first write to address 0 after reset loads the disable bit from write-data bit 7 on that clock edge. Every later write to address 0 leaves the bit unchanged until the next reset.
- R6: Every write to address 0 loads the arbitration priority from write-data bits 3:0 on the clock edge, whether or not the disable bit is locked.
- R7: A read of address 1 returns the mode in bits 1:0 and the written flag in bit 2, with the other bits zero. The flag is set by the first write to address 0 and is cleared only by reset.
- R8: Writes to address 1 or to any unmapped address change nothing. Reads of unmapped addresses return 0, and `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap_dat | input | 1 | Data-line mode strap |
| strap_berr | input | 1 | Bus-error-line mode strap |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| mode_o | output | 2 | Latched operating mode |
| rw_oe | output | 1 | Output enable for the read/write pin |
| arb_pri | output | 4 | Interrupt arbitration priority |

## Verification
A wrong mode latch shows on `mode_o` and on the status readback in the first cycle after reset is released. It also shows on `rw_oe`, because the reset value of the disable bit follows the mode. A lock that fails to engage, or that engages early, shows on `rw_oe` one clock edge after the second or the first write. A written flag that is lost or set without cause shows on the next read of address 1. The bench covers every strap pair, all sixteen priority values and both states of the lock.

// File: rtl/sys_cfg_once.sv
module sys_cfg_once #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_dat,
  input  logic              strap_berr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic [1:0]        mode_o,
  output logic              rw_oe,
  output logic [3:0]        arb_pri
);
  localparam logic [1:0] M_SINGLE = 2'b00;
  localparam logic [1:0] M_EXP8   = 2'b01;
  localparam logic [1:0] M_EXP16  = 2'b10;
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

  logic [1:0] mode_q, strap_mode;
  logic       rwd_q, wrote_q;
  logic [3:0] arb_q;
  logic       cfg_we;

  assign strap_mode = !strap_berr ? M_SINGLE : (strap_dat ? M_EXP16 : M_EXP8);
  assign cfg_we     = bus_wr && (bus_addr == A_CFG);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= strap_mode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rwd_q   <= (strap_mode == M_SINGLE);
      arb_q   <= 4'hF;
      wrote_q <= 1'b0;
    end else if (cfg_we) begin
      arb_q   <= bus_wdata[3:0];
      wrote_q <= 1'b1;
      if (!wrote_q) rwd_q <= bus_wdata[7];
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      if (bus_addr == A_CFG)       bus_rdata = {rwd_q, 3'b000, arb_q};
      else if (bus_addr == A_STAT) bus_rdata = {5'b00000, wrote_q, mode_q};
    end
  end

  assign mode_o  = mode_q;
  assign rw_oe   = !rwd_q;
  assign arb_pri = arb_q;
endmodule

module sys_cfg_once_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [1:0]        mode_o,
  input logic              rw_oe,
  input logic [3:0]        arb_pri,
  input logic              wrote_q
);
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_o));

  p_reset_vals_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (arb_pri == 4'hF && !wrote_q && rw_oe == (mode_o != 2'b00)));

  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> mode_o != 2'b11);

  p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wrote_q)) |-> $stable(rw_oe));

  p_arb_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bus_wr) && $past(bus_addr) == '0) |-> arb_pri == $past(bus_wdata[3:0]));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wrote_q)) |-> wrote_q);
endmodule

bind sys_cfg_once sys_cfg_once_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .mode_o(mode_o), .rw_oe(rw_oe),
  .arb_pri(arb_pri), .wrote_q(wrote_q)
);

// File: tb/sim_sys_cfg_once.sv
module sim_sys_cfg_once;
  localparam int CLK_P = 10;
  localparam int AW = 2;

  logic clk = 0, rst_n = 0, strap_dat = 0, strap_berr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] mode_o;
  logic rw_oe;
  logic [3:0] arb_pri;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sys_cfg_once #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_dat(strap_dat), .strap_berr(strap_berr),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .mode_o(mode_o), .rw_oe(rw_oe), .arb_pri(arb_pri));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_mode(input logic d, input logic b);
    return !b ? 2'b00 : (d ? 2'b10 : 2'b01);
  endfunction

  task automatic do_reset(input logic d, input logic b);
    @(negedge clk);
    rst_n = 0; strap_dat = !d; strap_berr = !b;
    repeat (3) @(negedge clk);
    strap_dat = d; strap_berr = b;
    @(negedge clk);
    rst_n = 1; strap_dat = !d; strap_berr = !b;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1;
    #1 v = bus_rdata;
    bus_rd = 0;
  endtask

  initial begin
    logic [7:0] v;
    logic [1:0] m;
    logic rwd;
    for (int s = 0; s < 4; s++) begin
      do_reset(s[0], s[1]);
      m = exp_mode(s[0], s[1]);
      rwd = (m == 2'b00);
      chk("R1 mode", mode_o, m);
      @(negedge clk);
      chk("R2 mode held", mode_o, m);
      chk("R3 arb reset", arb_pri, 4'hF);
      chk("R4 rw_oe reset", rw_oe, !rwd);
      rd(0, v); chk("R4 cfg read", v, {rwd, 3'b000, 4'hF});
      rd(1, v); chk("R7 stat read reset", v, {5'b0, 1'b0, m});
      #1 chk("R8 rdata idle", bus_rdata, 0);
      wr(1, 8'hFF); wr(2, 8'h00); wr(3, 8'hFF);
      rd(0, v); chk("R8 ignored writes cfg", v, {rwd, 3'b000, 4'hF});
      rd(1, v); chk("R8 ignored writes stat", v, {5'b0, 1'b0, m});
      rd(2, v); chk("R8 unmapped read", v, 0);
      wr(0, {!rwd, 3'b111, 4'h5});
      chk("R5 first write", rw_oe, rwd);
      chk("R6 arb first", arb_pri, 4'h5);
      rd(1, v); chk("R7 written set", v, {5'b0, 1'b1, m});
      for (int k = 0; k < 16; k++) begin
        wr(0, {rwd, 3'b000, 4'(k)});
        chk("R5 locked", rw_oe, rwd);
        chk("R6 arb sweep", arb_pri, k);
        rd(0, v); chk("R4 cfg readback", v, {!rwd, 3'b000, 4'(k)});
      end
      wr(1, 8'h00);
      rd(1, v); chk("R7 flag sticky", v, {5'b0, 1'b1, m});
      strap_berr = !strap_berr; @(negedge clk);
      chk("R2 straps ignored", mode_o, m);
    end
    do_reset(1, 1);
    @(negedge clk);
    rd(1, v); chk("R7 reset clears flag", v, 8'h02);
    wr(0, 8'h80);
    chk("R5 relock after reset", rw_oe, 0);
    done = 1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      done = 1;
    end
  end

  initial begin
    wait (done);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule